// File: doc/BRIEF.md
# Vector Store Instruction Decoder

This block takes one 32-bit instruction word per handshake and decides whether it is a legal vector store for the embedded vector extension of RISC-V. If it is, the block reports which of ten store forms it is. Each form is defined by the addressing mode, the sub-opcode carried in the second-source slot, and the segment field count. The block also reports the register indices that the form uses, the element-width code, whether the store is masked, and the segment field count or whole-register count.

Every accepted word produces exactly one output beat, legal or not. A legal beat raises `out_decode_valid`. An illegal beat raises `out_illegal` and clears every decoded field. The result sits in a single registered output stage with a valid/ready handshake on both sides. A downstream address generator or memory pipe consumes it from there.

Top module: `vst_decoder`

## Requirements
- R1: A word whose bits [6:0] differ from 7'b0100111 is illegal.
- R2: A word with bit 28 set is illegal, whatever its other fields hold.
- R3: For addressing mode 2'b00 in bits [27:26], the sub-opcode in bits [24:20] selects the form. 5'b00000 gives a plain unit store when bits [31:29] are zero, and a unit segment store otherwise. 5'b01000 gives a whole-register store. 5'b01011 gives a mask store. Every other sub-opcode is illegal. `out_rs2` reads zero for all unit-mode forms.
- R4: A whole-register store needs bit 25 = 1 and width bits [14:12] = 3'b000. Its register count `out_nregs` is bits [31:29] plus one and must be 1, 2, 4 or 8, otherwise the word is illegal. For every other form `out_nregs` is 0.
- R5: A mask store needs width 3'b000, bit 25 = 1 and bits [31:29] = 0, otherwise the word is illegal.
- R6: Mode 2'b10 is strided, 2'b01 is indexed-unordered and 2'b11 is indexed-ordered. Each is a segment form when bits [31:29] are nonzero. `out_rs2` carries bits [24:20]. `out_nfields` is bits [31:29] plus one for segment forms and 1 for all other legal forms.
- R7: Width codes 3'b000, 3'b101, 3'b110 and 3'b111 map to `out_ew` 0, 1, 2 and 3 (8, 16, 32 and 64 bits). Any other code makes a plain, segment, strided or indexed store illegal. Whole-register and mask stores report `out_ew` 0.
- R8: On a legal beat `out_masked` is the inverse of bit 25, `out_vs3` is bits [11:7] and `out_rs1` is bits [19:15]. On an illegal beat `out_illegal` is 1, `out_decode_valid` is 0 and all other data outputs are 0. Exactly one of these two flags is high on every beat.
- R9: `in_ready` is high when the stage is empty or `out_ready` is high. While `out_valid` is high and `out_ready` is low, every output stays unchanged.
- R10: While `rst_n` is low, `out_valid` is 0. After reset, every accepted word yields exactly one beat, and beats leave in acceptance order.
- R11: `out_kind` is one-hot on a legal beat and zero on an illegal one. The bit positions are: 0 plain unit, 1 mask, 2 strided, 3 indexed-unordered, 4 indexed-ordered, 5 whole-register, 6 unit segment, 7 strided segment, 8 indexed-unordered segment, 9 indexed-ordered segment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction word offered |
| in_ready | output | 1 | Stage can take a word this cycle |
| in_word | input | 32 | Instruction word |
| out_valid | output | 1 | Decode beat held |
| out_ready | input | 1 | Consumer takes the beat |
| out_kind | output | 10 | One-hot store form |
| out_vs3 | output | 5 | Data source vector register |
| out_rs1 | output | 5 | Base address integer register |
| out_rs2 | output | 5 | Stride register or index vector register |
| out_ew | output | 2 | Element-width code (log2 of bytes) |
| out_masked | output | 1 | Store is masked |
| out_nfields | output | 4 | Segment field count |
| out_nregs | output | 4 | Whole-register count |
| out_decode_valid | output | 1 | Beat is a legal store |
| out_illegal | output | 1 | Beat is an illegal word |

## Verification
The bench sends whole-register words with every register count from 1 to 8. A decoder that accepts 3, 5, 6 or 7 would mark those legal and report a count that no real store has. It also sends mask-store words with a single violated condition each (wide width, vm clear, nonzero count). A design that forgot one of the checks would pass these words as legal. Reserved width codes are applied in every addressing mode, and the forbidden sub-opcodes next to 01000 and 01011 are included. Together these catch a width table or sub-opcode compare that is too loose. Random back-pressure and a reset taken while a beat is held expose a stage that drops, duplicates or changes a beat that has not yet been taken.

// File: rtl/vst_pkg.sv
package vst_pkg;

  localparam int WORD_W    = 32;
  localparam int REG_W     = 5;
  localparam int KIND_N    = 10;
  localparam int CNT_W     = 4;
  localparam int EW_W      = 2;
  localparam logic [6:0] STORE_OPC = 7'b0100111;

  // one-hot positions of out_kind
  localparam int K_UNIT   = 0;
  localparam int K_MASK   = 1;
  localparam int K_STRD   = 2;
  localparam int K_IDXU   = 3;
  localparam int K_IDXO   = 4;
  localparam int K_WHOLE  = 5;
  localparam int K_USEG   = 6;
  localparam int K_SSEG   = 7;
  localparam int K_IUSEG  = 8;
  localparam int K_IOSEG  = 9;

  localparam logic [4:0] SUB_PLAIN = 5'b00000;
  localparam logic [4:0] SUB_WHOLE = 5'b01000;
  localparam logic [4:0] SUB_MASK  = 5'b01011;

  typedef enum logic [1:0] {
    AM_UNIT = 2'b00,
    AM_IDXU = 2'b01,
    AM_STRD = 2'b10,
    AM_IDXO = 2'b11
  } addr_mode_e;

  typedef struct packed {
    logic [2:0]       nf;
    logic             mew;
    addr_mode_e       mode;
    logic             vm;
    logic [REG_W-1:0] slot2;
    logic [REG_W-1:0] base;
    logic [2:0]       wcode;
    logic [REG_W-1:0] vsrc;
    logic [6:0]       opc;
  } raw_word_t;

  typedef struct packed {
    logic [KIND_N-1:0] kind;
    logic [REG_W-1:0]  vs3;
    logic [REG_W-1:0]  rs1;
    logic [REG_W-1:0]  rs2;
    logic [EW_W-1:0]   ew;
    logic              masked;
    logic [CNT_W-1:0]  nfields;
    logic [CNT_W-1:0]  nregs;
    logic              ok;
    logic              bad;
  } dec_beat_t;

  localparam int BEAT_W = $bits(dec_beat_t);

endpackage

// File: rtl/vst_width_map.sv
module vst_width_map
  import vst_pkg::*;
(
  input  logic [2:0]      wcode,
  output logic [EW_W-1:0] ew,
  output logic            ew_ok
);
  always_comb begin
    ew    = '0;
    ew_ok = 1'b0;
    unique case (wcode)
      3'b000: begin ew = 2'd0; ew_ok = 1'b1; end
      3'b101: begin ew = 2'd1; ew_ok = 1'b1; end
      3'b110: begin ew = 2'd2; ew_ok = 1'b1; end
      3'b111: begin ew = 2'd3; ew_ok = 1'b1; end
      default: begin ew = '0; ew_ok = 1'b0; end
    endcase
  end
endmodule

// File: rtl/vst_classify.sv
module vst_classify
  import vst_pkg::*;
(
  input  raw_word_t       raw,
  input  logic [EW_W-1:0] ew,
  input  logic            ew_ok,
  output dec_beat_t       beat
);
  logic              legal;
  logic [KIND_N-1:0] kind;
  logic              seg;
  logic              pow2_cnt;
  logic              uses_rs2;
  logic              uses_ew;

  assign seg      = (raw.nf != 3'd0);
  assign pow2_cnt = (raw.nf == 3'd0) || (raw.nf == 3'd1) ||
                    (raw.nf == 3'd3) || (raw.nf == 3'd7);

  always_comb begin
    legal    = 1'b0;
    kind     = '0;
    uses_rs2 = 1'b0;
    uses_ew  = 1'b0;
    if (raw.opc == STORE_OPC && !raw.mew) begin
      unique case (raw.mode)
        AM_UNIT: begin
          if (raw.slot2 == SUB_PLAIN) begin
            legal   = ew_ok;
            uses_ew = 1'b1;
            kind[seg ? K_USEG : K_UNIT] = ew_ok;
          end else if (raw.slot2 == SUB_WHOLE) begin
            legal = raw.vm && (raw.wcode == 3'b000) && pow2_cnt;
            kind[K_WHOLE] = legal;
          end else if (raw.slot2 == SUB_MASK) begin
            legal = raw.vm && (raw.wcode == 3'b000) && !seg;
            kind[K_MASK] = legal;
          end
        end
        AM_STRD: begin
          legal    = ew_ok;
          uses_rs2 = 1'b1;
          uses_ew  = 1'b1;
          kind[seg ? K_SSEG : K_STRD] = ew_ok;
        end
        AM_IDXU: begin
          legal    = ew_ok;
          uses_rs2 = 1'b1;
          uses_ew  = 1'b1;
          kind[seg ? K_IUSEG : K_IDXU] = ew_ok;
        end
        AM_IDXO: begin
          legal    = ew_ok;
          uses_rs2 = 1'b1;
          uses_ew  = 1'b1;
          kind[seg ? K_IOSEG : K_IDXO] = ew_ok;
        end
        default: legal = 1'b0;
      endcase
    end
  end

  always_comb begin
    beat     = '0;
    beat.bad = !legal;
    if (legal) begin
      beat.ok      = 1'b1;
      beat.kind    = kind;
      beat.vs3     = raw.vsrc;
      beat.rs1     = raw.base;
      beat.rs2     = uses_rs2 ? raw.slot2 : '0;
      beat.ew      = uses_ew ? ew : '0;
      beat.masked  = !raw.vm;
      beat.nfields = (uses_ew && seg) ? CNT_W'(raw.nf) + CNT_W'(1) : CNT_W'(1);
      beat.nregs   = kind[K_WHOLE] ? CNT_W'(raw.nf) + CNT_W'(1) : '0;
    end
  end
endmodule

// File: rtl/vst_out_stage.sv
module vst_out_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic         vld_q, vld_d;
  logic [W-1:0] dat_q, dat_d;
  logic         load_en;

  assign in_ready = !vld_q || out_ready;
  assign load_en  = in_valid && in_ready;

  always_comb begin
    vld_d = vld_q;
    dat_d = dat_q;
    if (load_en) begin
      vld_d = 1'b1;
      dat_d = in_data;
    end else if (out_ready) begin
      vld_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else begin
      vld_q <= vld_d;
      if (load_en) dat_q <= dat_d;
    end
  end

  assign out_valid = vld_q;
  assign out_data  = dat_q;
endmodule

// File: rtl/vst_decoder.sv
module vst_decoder
  import vst_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_word,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [KIND_N-1:0] out_kind,
  output logic [REG_W-1:0]  out_vs3,
  output logic [REG_W-1:0]  out_rs1,
  output logic [REG_W-1:0]  out_rs2,
  output logic [EW_W-1:0]   out_ew,
  output logic              out_masked,
  output logic [CNT_W-1:0]  out_nfields,
  output logic [CNT_W-1:0]  out_nregs,
  output logic              out_decode_valid,
  output logic              out_illegal
);
  raw_word_t       raw;
  logic [EW_W-1:0] ew;
  logic            ew_ok;
  dec_beat_t       beat_d;
  dec_beat_t       beat_q;
  logic [BEAT_W-1:0] beat_q_bits;

  assign raw = raw_word_t'(in_word);

  vst_width_map u_wmap (
    .wcode (raw.wcode),
    .ew    (ew),
    .ew_ok (ew_ok)
  );

  vst_classify u_cls (
    .raw   (raw),
    .ew    (ew),
    .ew_ok (ew_ok),
    .beat  (beat_d)
  );

  vst_out_stage #(.W(BEAT_W)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (beat_d),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (beat_q_bits)
  );

  assign beat_q           = dec_beat_t'(beat_q_bits);
  assign out_kind         = beat_q.kind;
  assign out_vs3          = beat_q.vs3;
  assign out_rs1          = beat_q.rs1;
  assign out_rs2          = beat_q.rs2;
  assign out_ew           = beat_q.ew;
  assign out_masked       = beat_q.masked;
  assign out_nfields      = beat_q.nfields;
  assign out_nregs        = beat_q.nregs;
  assign out_decode_valid = beat_q.ok;
  assign out_illegal      = beat_q.bad;
endmodule

// File: rtl/vst_decoder_chk.sv
module vst_decoder_chk
  import vst_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [KIND_N-1:0] out_kind,
  input logic [REG_W-1:0]  out_vs3,
  input logic [REG_W-1:0]  out_rs1,
  input logic [REG_W-1:0]  out_rs2,
  input logic [EW_W-1:0]   out_ew,
  input logic              out_masked,
  input logic [CNT_W-1:0]  out_nfields,
  input logic [CNT_W-1:0]  out_nregs,
  input logic              out_decode_valid,
  input logic              out_illegal
);
  a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_kind) && $stable(out_vs3) &&
      $stable(out_rs1) && $stable(out_rs2) && $stable(out_ew) && $stable(out_masked) &&
      $stable(out_nfields) && $stable(out_nregs) && $stable(out_decode_valid) &&
      $stable(out_illegal)));

  a_r10_accept_gives_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  a_r8_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_decode_valid != out_illegal));

  a_r11_kind_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_decode_valid ? $onehot(out_kind) : (out_kind == '0)));

  a_r4_whole_count: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_kind[K_WHOLE]) |->
      (out_nregs == 4'd1 || out_nregs == 4'd2 || out_nregs == 4'd4 || out_nregs == 4'd8));

  a_r5_mask_form: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_kind[K_MASK]) |-> (!out_masked && out_ew == '0 && out_nfields == 4'd1));

  a_r9_ready_when_taken: assert property (@(posedge clk) disable iff (!rst_n)
    out_ready |-> in_ready);
endmodule

bind vst_decoder vst_decoder_chk u_chk (.*);

// File: tb/vst_decoder_test.sv
`timescale 1ns/100ps
module vst_decoder_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_ready, out_valid, out_ready;
  logic [31:0] in_word;
  logic [9:0]  out_kind;
  logic [4:0]  out_vs3, out_rs1, out_rs2;
  logic [1:0]  out_ew;
  logic        out_masked, out_decode_valid, out_illegal;
  logic [3:0]  out_nfields, out_nregs;

  always #2 clk = ~clk;  // 250 MHz

  vst_decoder uut (.*);

  typedef struct packed {
    logic [9:0] kind;
    logic [4:0] vs3, rs1, rs2;
    logic [1:0] ew;
    logic       masked;
    logic [3:0] nfields, nregs;
    logic       ok, bad;
  } exp_t;

  int n_cmp = 0;
  int n_bad = 0;
  exp_t        exp_q[$];
  logic [31:0] word_q[$];
  logic [31:0] stim[$];
  bit          acc_flag = 0;
  bit          run_mon = 0;
  bit          prev_hold = 0;
  exp_t        prev_out;

  function automatic logic [31:0] mk(int nf, int mew, int mode, int vm, int s2,
                                     int b, int w, int vs);
    return {3'(nf), 1'(mew), 2'(mode), 1'(vm), 5'(s2), 5'(b), 3'(w), 5'(vs), 7'h27};
  endfunction

  // behavioural reference
  function automatic int ew_of(int w);
    if (w == 0) return 0;
    if (w == 5) return 1;
    if (w == 6) return 2;
    if (w == 7) return 3;
    return -1;
  endfunction

  function automatic exp_t ref_model(logic [31:0] w, output string tag);
    exp_t e;
    int nf = w[31:29], mode = w[27:26], sub = w[24:20], wd = w[14:12];
    int ewv = ew_of(wd);
    int k = -1;
    e = '0;
    tag = "R1";
    if (w[6:0] != 7'h27) k = -1;
    else if (w[28]) begin tag = "R2"; k = -1; end
    else if (mode == 0) begin
      tag = "R3";
      if (sub == 0) begin tag = "R7"; if (ewv >= 0) k = (nf == 0) ? 0 : 6; end
      else if (sub == 8) begin
        tag = "R4";
        if (w[25] && wd == 0 && (nf == 0 || nf == 1 || nf == 3 || nf == 7)) k = 5;
      end else if (sub == 11) begin
        tag = "R5";
        if (w[25] && wd == 0 && nf == 0) k = 1;
      end
    end else begin
      tag = (ewv >= 0) ? "R6" : "R7";
      if (ewv >= 0) begin
        if (mode == 2) k = (nf == 0) ? 2 : 7;
        else if (mode == 1) k = (nf == 0) ? 3 : 8;
        else k = (nf == 0) ? 4 : 9;
      end
    end
    if (k < 0) begin
      e.bad = 1'b1;
      return e;
    end
    e.ok = 1'b1;
    e.kind[k] = 1'b1;
    e.vs3 = w[11:7];
    e.rs1 = w[19:15];
    e.masked = !w[25];
    e.nfields = 4'd1;
    if (mode != 0) e.rs2 = w[24:20];
    if (k != 1 && k != 5) e.ew = 2'(ewv);
    if (k >= 6) e.nfields = 4'(nf + 1);
    if (k == 5) e.nregs = 4'(nf + 1);
    return e;
  endfunction

  task automatic fail(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_bad++;
    $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
  endtask

  function automatic exp_t cur_out();
    exp_t o;
    o = {out_kind, out_vs3, out_rs1, out_rs2, out_ew, out_masked,
         out_nfields, out_nregs, out_decode_valid, out_illegal};
    return o;
  endfunction

  // monitor: samples 1 ns after the falling edge, 1 ns before the rising edge
  always @(negedge clk) begin
    #1;
    if (run_mon && rst_n) begin
      exp_t o;
      o = cur_out();
      n_cmp++;
      if (in_ready !== (!out_valid || out_ready))
        fail("R9", "in_ready", 32'(in_ready), 32'(!out_valid || out_ready));
      if (prev_hold) begin
        n_cmp++;
        if (!out_valid || o !== prev_out)
          fail("R9", "held beat changed", 32'(o), 32'(prev_out));
      end
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          n_cmp++;
          fail("R10", "beat with nothing accepted", 32'(o), 32'h0);
        end else begin
          exp_t e;
          string tg;
          logic [31:0] wd;
          e = exp_q.pop_front();
          wd = word_q.pop_front();
          e = ref_model(wd, tg);
          n_cmp += 3;
          if (o !== e) fail(tg, $sformatf("word %h beat", wd), 32'(o), 32'(e));
          if (out_decode_valid && out_masked !== !wd[25])
            fail("R8", "masked", 32'(out_masked), 32'(!wd[25]));
          if ($countones(out_kind) != (out_decode_valid ? 1 : 0))
            fail("R11", "kind count", 32'(out_kind), 32'(e.kind));
        end
      end
      prev_hold = out_valid && !out_ready;
      prev_out  = o;
      if (in_valid && in_ready) begin
        exp_t e;
        string tg;
        e = ref_model(in_word, tg);
        exp_q.push_back(e);
        word_q.push_back(in_word);
        acc_flag = 1;
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : driver
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0; in_word = '0;
    repeat (3) @(negedge clk);
    #1;
    n_cmp++;
    if (out_valid !== 1'b0) fail("R10", "out_valid in reset", 32'(out_valid), 32'h0);
    // R1 opcode, R2 mew
    stim.push_back(mk(0,0,0,1,0,3,0,4) ^ 32'h1);
    stim.push_back(32'h0000_0007);
    stim.push_back(mk(0,1,0,1,0,3,0,4));
    stim.push_back(mk(2,1,2,0,5,3,6,4));
    // R3 unit forms and forbidden sub-opcodes
    stim.push_back(mk(0,0,0,1,0,9,5,17));
    stim.push_back(mk(4,0,0,0,0,9,6,17));
    stim.push_back(mk(0,0,0,1,9,2,0,1));
    stim.push_back(mk(0,0,0,1,10,2,0,1));
    stim.push_back(mk(0,0,0,1,1,2,0,1));
    // R4 whole-register counts 1..8 and violations
    for (int n = 0; n < 8; n++) stim.push_back(mk(n,0,0,1,8,n+1,0,n*3));
    stim.push_back(mk(1,0,0,0,8,1,0,2));
    stim.push_back(mk(1,0,0,1,8,1,5,2));
    // R5 mask store and each violation
    stim.push_back(mk(0,0,0,1,11,7,0,30));
    stim.push_back(mk(0,0,0,1,11,7,7,30));
    stim.push_back(mk(0,0,0,0,11,7,0,30));
    stim.push_back(mk(1,0,0,1,11,7,0,30));
    // R6 strided / indexed, plain and segment
    for (int m = 1; m < 4; m++) begin
      stim.push_back(mk(0,0,m,0,12,5,7,6));
      stim.push_back(mk(7,0,m,1,31,5,0,6));
      stim.push_back(mk(2,0,m,0,1,5,6,6));
    end
    // R7 reserved widths in every mode
    for (int m = 0; m < 4; m++)
      for (int w = 1; w < 5; w++) stim.push_back(mk(0,0,m,1,0,1,w,1));
    for (int i = 0; i < 600; i++) begin
      logic [31:0] r;
      r = $urandom;
      if ($urandom % 8 != 0) r[6:0] = 7'h27;
      if ($urandom % 4 != 0) r[28] = 1'b0;
      if ($urandom % 3 == 0) r[24:20] = ($urandom % 2) ? 5'd8 : 5'd11;
      stim.push_back(r);
    end
    @(negedge clk); #0.5;
    rst_n = 1'b1;
    run_mon = 1;
    for (int idx = 0; idx < stim.size(); ) begin
      @(negedge clk); #0.5;
      if (acc_flag) begin idx++; acc_flag = 0; end
      in_valid  = (idx < stim.size()) && ($urandom % 4 != 0);
      in_word   = (idx < stim.size()) ? stim[idx] : 32'h0;
      out_ready = (idx < 60) ? 1'b1 : ($urandom % 3 != 0);
    end
    in_valid = 1'b0; out_ready = 1'b1;
    repeat (4) @(negedge clk);
    // R10: reset while a beat is held
    #0.5;
    in_valid = 1'b1; out_ready = 1'b0; in_word = mk(0,0,2,1,4,4,5,4);
    @(negedge clk); #0.5;
    in_valid = 1'b0;
    @(negedge clk); #0.5;
    run_mon = 0;
    rst_n = 1'b0;
    #0.5;
    n_cmp++;
    if (out_valid !== 1'b0) fail("R10", "out_valid after reset", 32'(out_valid), 32'h0);
    exp_q.delete(); word_q.delete();
    prev_hold = 0;
    @(negedge clk); #0.5;
    rst_n = 1'b1; out_ready = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    n_cmp++;
    if (out_valid !== 1'b0) fail("R10", "beat after reset", 32'(out_valid), 32'h0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule